// File: doc/BRIEF.md
# SD Command Issue Register Front End

This block is the software-facing register file of an SD/MMC host controller. Software writes the command index, a 32-bit argument, a response-type code, the block length and the block count over a byte-wide register port. It then writes the control byte, which carries the command kind and the transfer direction. When the start bit in that write is set, the block sends a single-cycle start pulse to the command sequencer, which stays outside this block. Decoded views of the command kind and of the response-type code go to the sequencer as level outputs.

A 16-byte response buffer sits in the register window. A simple loader port stands in for the card-side receiver and delivers bytes in transmission order. The buffer stores the first fifteen of them one offset above their index and wraps the last one to the base of the window. This is the layout that existing driver software expects. Software can clear the buffer with a self-clearing bit in the control byte.

Top module: `sdcmd_front`

## Requirements
- R1: After reset, every register address reads 0x00, and `cmd_start`, `cmd_arg`, `blk_count`, `blk_len_m1` and `blk_flags` are zero.
- R2: Offset 0x01 holds the command index and offset 0x02 the response-type code. Offsets 0x04..0x07 hold the argument, least significant byte at 0x04. Offsets 0x0E..0x0F hold the block count, low byte first. Each mapped byte reads back as written and drives its output. Every other address below 0x10, and every address from 0x20 up, reads 0x00 and ignores writes. Writes to the response window 0x10..0x1F are also ignored.
- R3: The control byte is at offset 0x00. Bits 7:4 are the command kind (`cmd_kind`) and bit 2 is the write direction (`cmd_write`). Bits 3 and 1 always read 0. `cmd_has_data` is high for kinds 1..4, `cmd_multi` for kinds 3 and 4, and `cmd_stop` for kind 7.
- R4: A control write with bit 0 set while `seq_busy` is low drives `cmd_start` high for exactly the next cycle. During that cycle control bit 0 reads 1, and afterwards it reads 0.
- R5: A control write with bit 0 set while `seq_busy` is high produces no start pulse. The other control fields of that write still take effect.
- R6: The block-length register spans offsets 0x0C (bits 7:0) and 0x0D (bits 15:8). Bits 10:0 are the block size minus one (`blk_len_m1`) and bits 15:11 are flags (`blk_flags`). A write to 0x0C leaves the flags unchanged.
- R7: `rsp_busy` is high exactly when the response-type code is 9 (R1b with busy). `rsp_long` is high exactly when the code is 2 (136-bit R2).
- R8: Response bytes pushed on `rsp_push` are numbered k = 0, 1, 2, … in arrival order. Byte k, for k from 0 to 14, reads at offset 0x11+k, and byte 15 reads at 0x10. Pushes after the sixteenth are ignored. Each start pulse restarts the numbering at k = 0.
- R9: A control write with bit 3 set zeroes all 16 response bytes at that clock edge and restarts the numbering. This takes priority over a push in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte address for reads and writes |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| seq_busy | input | 1 | Command sequencer busy |
| cmd_start | output | 1 | One-cycle command start pulse |
| cmd_index | output | 8 | Command index |
| cmd_arg | output | 8*ARG_BYTES | Command argument |
| cmd_rsp_code | output | 8 | Response-type code |
| cmd_kind | output | 4 | Command kind |
| cmd_write | output | 1 | Write direction |
| cmd_has_data | output | 1 | Kind moves data (1..4) |
| cmd_multi | output | 1 | Multi-block kind (3, 4) |
| cmd_stop | output | 1 | Stop-transmission kind (7) |
| rsp_busy | output | 1 | Response code is the busy type |
| rsp_long | output | 1 | Response code is the long type |
| blk_len_m1 | output | LEN_W | Block size minus one |
| blk_flags | output | 16-LEN_W | Block-length control flags |
| blk_count | output | 16 | Block count |
| rsp_push | input | 1 | Response byte valid |
| rsp_din | input | 8 | Response byte |

## Verification
The bench builds the block with its defaults: a 6-bit address, a 4-byte argument, an 11-bit length field and 16 response bytes. With these values the 64-address space is small enough to sweep every address for reset value, readback and ignored writes. All sixteen command kinds and all sixteen low response codes are walked through the decode outputs. A full sixteen-byte load, plus overflow pushes, covers every rotated slot. The same load brings within reach the wrap of byte 15 to the base offset, counter restart by a start pulse, and a clear that collides with a push.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;
   // register offsets whose positions software decodes
   localparam int OFF_CTRL = 'h00;
   localparam int OFF_IDX  = 'h01;
   localparam int OFF_CODE = 'h02;
   localparam int OFF_ARG  = 'h04;
   localparam int OFF_LEN  = 'h0C;
   localparam int OFF_CNT  = 'h0E;
   localparam int OFF_RSP  = 'h10;

   // control byte bit positions
   localparam int CB_START = 0;
   localparam int CB_WDIR  = 2;
   localparam int CB_CLR   = 3;

   typedef enum logic [3:0] {
      KIND_NODATA = 4'd0,
      KIND_WR_ONE = 4'd1,
      KIND_RD_ONE = 4'd2,
      KIND_WR_MUL = 4'd3,
      KIND_RD_MUL = 4'd4,
      KIND_STOP   = 4'd7
   } cmd_kind_e;

   localparam logic [7:0] CODE_LONG = 8'd2;
   localparam logic [7:0] CODE_BUSY = 8'd9;
endpackage

// File: rtl/sdcmd_decode.sv
module sdcmd_decode
   import sdcmd_pkg::*;
(
   input  logic [3:0] kind,
   input  logic [7:0] code,
   output logic       has_data,
   output logic       multi,
   output logic       stop,
   output logic       rsp_busy,
   output logic       rsp_long
);
   always_comb begin
      has_data = 1'b0;
      multi    = 1'b0;
      stop     = 1'b0;
      case (kind)
         KIND_WR_ONE, KIND_RD_ONE: has_data = 1'b1;
         KIND_WR_MUL, KIND_RD_MUL: begin
            has_data = 1'b1;
            multi    = 1'b1;
         end
         KIND_STOP: stop = 1'b1;
         default: ;
      endcase
   end

   assign rsp_busy = (code == CODE_BUSY);
   assign rsp_long = (code == CODE_LONG);
endmodule

// File: rtl/sdcmd_regs.sv
module sdcmd_regs
   import sdcmd_pkg::*;
#(
   parameter int ADDR_W    = 6,
   parameter int ARG_BYTES = 4,
   parameter int LEN_W     = 11
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr_en,
   input  logic [ADDR_W-1:0]      addr,
   input  logic [7:0]             wdata,
   input  logic                   seq_busy,
   output logic                   start_pulse,
   output logic                   fifo_clr,
   output logic [7:0]             idx,
   output logic [7:0]             code,
   output logic [8*ARG_BYTES-1:0] arg,
   output logic [3:0]             kind,
   output logic                   wdir,
   output logic [LEN_W-1:0]       len_m1,
   output logic [15-LEN_W:0]      len_flags,
   output logic [15:0]            blk_cnt,
   output logic [7:0]             rdata
);
   localparam int CNT_BYTES = 2;

   if (ARG_BYTES < 1 || ARG_BYTES > 4) begin : g_bad_arg
      $error("ARG_BYTES must lie in 1..4");
   end
   if (LEN_W < 9 || LEN_W > 15) begin : g_bad_len
      $error("LEN_W must lie in 9..15");
   end
   if (ADDR_W < 6) begin : g_bad_addr
      $error("ADDR_W must be at least 6");
   end

   logic                   start_q;
   logic [7:0]             idx_q, code_q;
   logic [8*ARG_BYTES-1:0] arg_q;
   logic [3:0]             kind_q;
   logic                   wdir_q;
   logic [15:0]            lenreg_q;
   logic [15:0]            cnt_q;
   logic                   wr_ctrl;

   assign wr_ctrl = wr_en && (addr == ADDR_W'(OFF_CTRL));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         start_q  <= 1'b0;
         idx_q    <= '0;
         code_q   <= '0;
         arg_q    <= '0;
         kind_q   <= '0;
         wdir_q   <= 1'b0;
         lenreg_q <= '0;
         cnt_q    <= '0;
      end else begin
         start_q <= wr_ctrl && wdata[CB_START] && !seq_busy;
         if (wr_ctrl) begin
            kind_q <= wdata[7:4];
            wdir_q <= wdata[CB_WDIR];
         end
         if (wr_en && addr == ADDR_W'(OFF_IDX))  idx_q  <= wdata;
         if (wr_en && addr == ADDR_W'(OFF_CODE)) code_q <= wdata;
         for (int b = 0; b < ARG_BYTES; b++)
            if (wr_en && addr == ADDR_W'(OFF_ARG + b)) arg_q[8*b +: 8] <= wdata;
         for (int b = 0; b < 2; b++)
            if (wr_en && addr == ADDR_W'(OFF_LEN + b)) lenreg_q[8*b +: 8] <= wdata;
         for (int b = 0; b < CNT_BYTES; b++)
            if (wr_en && addr == ADDR_W'(OFF_CNT + b)) cnt_q[8*b +: 8] <= wdata;
      end
   end

   assign fifo_clr    = wr_ctrl && wdata[CB_CLR];
   assign start_pulse = start_q;
   assign idx         = idx_q;
   assign code        = code_q;
   assign arg         = arg_q;
   assign kind        = kind_q;
   assign wdir        = wdir_q;
   assign len_m1      = lenreg_q[LEN_W-1:0];
   assign len_flags   = lenreg_q[15:LEN_W];
   assign blk_cnt     = cnt_q;

   always_comb begin
      rdata = '0;
      if (addr == ADDR_W'(OFF_CTRL)) rdata = {kind_q, 1'b0, wdir_q, 1'b0, start_q};
      if (addr == ADDR_W'(OFF_IDX))  rdata = idx_q;
      if (addr == ADDR_W'(OFF_CODE)) rdata = code_q;
      for (int b = 0; b < ARG_BYTES; b++)
         if (addr == ADDR_W'(OFF_ARG + b)) rdata = arg_q[8*b +: 8];
      for (int b = 0; b < 2; b++)
         if (addr == ADDR_W'(OFF_LEN + b)) rdata = lenreg_q[8*b +: 8];
      for (int b = 0; b < CNT_BYTES; b++)
         if (addr == ADDR_W'(OFF_CNT + b)) rdata = cnt_q[8*b +: 8];
   end
endmodule

// File: rtl/sdcmd_rsp_buf.sv
module sdcmd_rsp_buf #(
   parameter int RSP_BYTES = 16,
   parameter bit ROTATE    = 1'b1,
   localparam int SLOT_W   = $clog2(RSP_BYTES)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   clear,
   input  logic                   restart,
   input  logic                   push,
   input  logic [7:0]             din,
   input  logic [SLOT_W-1:0]      rd_slot,
   output logic [7:0]             rd_byte,
   output logic [8*RSP_BYTES-1:0] flat
);
   if ((1 << SLOT_W) != RSP_BYTES) begin : g_bad_depth
      $error("RSP_BYTES must be a power of two");
   end

   logic [SLOT_W:0]   ld_cnt;
   logic              full;
   logic [SLOT_W-1:0] tgt;
   logic [7:0]        slot_q [RSP_BYTES];

   assign full = (ld_cnt == (SLOT_W+1)'(RSP_BYTES));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                ld_cnt <= '0;
      else if (clear || restart) ld_cnt <= '0;
      else if (push && !full)    ld_cnt <= ld_cnt + 1'b1;
   end

   // slot that receives the byte numbered ld_cnt
   if (ROTATE) begin : g_rot
      assign tgt = ld_cnt[SLOT_W-1:0] + 1'b1;
   end else begin : g_lin
      assign tgt = ld_cnt[SLOT_W-1:0];
   end

   for (genvar s = 0; s < RSP_BYTES; s++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                       slot_q[s] <= '0;
         else if (clear)                                   slot_q[s] <= '0;
         else if (push && !full && tgt == SLOT_W'(s))      slot_q[s] <= din;
      end
      assign flat[8*s +: 8] = slot_q[s];
   end

   assign rd_byte = slot_q[rd_slot];
endmodule

// File: rtl/sdcmd_front.sv
module sdcmd_front
   import sdcmd_pkg::*;
#(
   parameter int ADDR_W    = 6,
   parameter int ARG_BYTES = 4,
   parameter int LEN_W     = 11,
   parameter int RSP_BYTES = 16,
   localparam int SLOT_W   = $clog2(RSP_BYTES)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   reg_wr,
   input  logic [ADDR_W-1:0]      reg_addr,
   input  logic [7:0]             reg_wdata,
   output logic [7:0]             reg_rdata,
   input  logic                   seq_busy,
   output logic                   cmd_start,
   output logic [7:0]             cmd_index,
   output logic [8*ARG_BYTES-1:0] cmd_arg,
   output logic [7:0]             cmd_rsp_code,
   output logic [3:0]             cmd_kind,
   output logic                   cmd_write,
   output logic                   cmd_has_data,
   output logic                   cmd_multi,
   output logic                   cmd_stop,
   output logic                   rsp_busy,
   output logic                   rsp_long,
   output logic [LEN_W-1:0]       blk_len_m1,
   output logic [15-LEN_W:0]      blk_flags,
   output logic [15:0]            blk_count,
   input  logic                   rsp_push,
   input  logic [7:0]             rsp_din
);
   if (RSP_BYTES != 16) begin : g_bad_rsp
      $error("response window holds exactly 16 bytes");
   end

   logic                   fifo_clr;
   logic [7:0]             cfg_rd, rsp_rd;
   logic [8*RSP_BYTES-1:0] rsp_flat;
   logic                   in_rsp;

   sdcmd_regs #(.ADDR_W(ADDR_W), .ARG_BYTES(ARG_BYTES), .LEN_W(LEN_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
      .seq_busy(seq_busy), .start_pulse(cmd_start), .fifo_clr(fifo_clr),
      .idx(cmd_index), .code(cmd_rsp_code), .arg(cmd_arg), .kind(cmd_kind),
      .wdir(cmd_write), .len_m1(blk_len_m1), .len_flags(blk_flags),
      .blk_cnt(blk_count), .rdata(cfg_rd)
   );

   sdcmd_rsp_buf #(.RSP_BYTES(RSP_BYTES), .ROTATE(1'b1)) u_rsp (
      .clk(clk), .rst_n(rst_n), .clear(fifo_clr), .restart(cmd_start),
      .push(rsp_push), .din(rsp_din), .rd_slot(reg_addr[SLOT_W-1:0]),
      .rd_byte(rsp_rd), .flat(rsp_flat)
   );

   sdcmd_decode u_dec (
      .kind(cmd_kind), .code(cmd_rsp_code), .has_data(cmd_has_data),
      .multi(cmd_multi), .stop(cmd_stop), .rsp_busy(rsp_busy), .rsp_long(rsp_long)
   );

   assign in_rsp    = (reg_addr >= ADDR_W'(OFF_RSP)) && (reg_addr < ADDR_W'(OFF_RSP + RSP_BYTES));
   assign reg_rdata = in_rsp ? rsp_rd : cfg_rd;
endmodule

// File: rtl/sdcmd_front_chk.sv
module sdcmd_front_chk #(
   parameter int ADDR_W    = 6,
   parameter int LEN_W     = 11,
   parameter int RSP_BYTES = 16
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   reg_wr,
   input logic [ADDR_W-1:0]      reg_addr,
   input logic [7:0]             reg_wdata,
   input logic                   seq_busy,
   input logic                   cmd_start,
   input logic [7:0]             cmd_index,
   input logic                   cmd_has_data,
   input logic                   cmd_stop,
   input logic [15-LEN_W:0]      blk_flags,
   input logic [8*RSP_BYTES-1:0] rsp_flat
);
   logic ctl_wr;
   assign ctl_wr = reg_wr && (reg_addr == ADDR_W'(0));

   a_r4_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_start |=> !cmd_start);

   a_r4_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_start |-> $past(ctl_wr && reg_wdata[0] && !seq_busy));

   a_r5_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr && reg_wdata[0] && seq_busy) |=> !cmd_start);

   a_r9_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr && reg_wdata[3]) |=> (rsp_flat == '0));

   a_r6_flags_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == ADDR_W'(12)) |=> $stable(blk_flags));

   a_r2_index_load: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == ADDR_W'(1)) |=> (cmd_index == $past(reg_wdata)));

   a_r3_stop_no_data: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_stop |-> !cmd_has_data);
endmodule

bind sdcmd_front sdcmd_front_chk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .RSP_BYTES(RSP_BYTES)) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
   .seq_busy(seq_busy), .cmd_start(cmd_start), .cmd_index(cmd_index),
   .cmd_has_data(cmd_has_data), .cmd_stop(cmd_stop), .blk_flags(blk_flags),
   .rsp_flat(rsp_flat)
);

// File: tb/sdcmd_front_test.sv
`timescale 1ns/1ps
module sdcmd_front_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [5:0]  reg_addr = '0;
   logic [7:0]  reg_wdata = '0;
   logic [7:0]  reg_rdata;
   logic        seq_busy = 1'b0;
   logic        cmd_start;
   logic [7:0]  cmd_index;
   logic [31:0] cmd_arg;
   logic [7:0]  cmd_rsp_code;
   logic [3:0]  cmd_kind;
   logic        cmd_write, cmd_has_data, cmd_multi, cmd_stop, rsp_busy, rsp_long;
   logic [10:0] blk_len_m1;
   logic [4:0]  blk_flags;
   logic [15:0] blk_count;
   logic        rsp_push = 1'b0;
   logic [7:0]  rsp_din = '0;

   int n_chk = 0;
   int n_bad = 0;
   logic [7:0] wv [64];

   always #2.5 clk = ~clk;

   sdcmd_front uut (.*);

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [5:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
      #1;
   endtask

   task automatic rd_chk(input string req, input logic [5:0] a, input logic [7:0] exp);
      @(negedge clk);
      reg_addr = a;
      #1;
      chk(req, reg_rdata, exp);
   endtask

   task automatic push(input logic [7:0] d);
      @(negedge clk);
      rsp_push = 1'b1; rsp_din = d;
      @(negedge clk);
      rsp_push = 1'b0;
   endtask

   function automatic bit mapped(input int a);
      return a == 1 || a == 2 || (a >= 4 && a <= 7) || (a >= 12 && a <= 15);
   endfunction

   function automatic logic [7:0] pat(input int k);
      return 8'(8'hC0 ^ (k * 7));
   endfunction

   initial begin
      #(200000 * 5);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual expired expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      for (int a = 0; a < 64; a++) rd_chk("R1", 6'(a), 8'h00);
      chk("R1 start", cmd_start, 0);
      chk("R1 arg", cmd_arg, 0);
      chk("R1 count", blk_count, 0);
      chk("R1 len", blk_len_m1, 0);
      chk("R1 flags", blk_flags, 0);

      // R2 sweep of every non-control address
      for (int p = 0; p < 2; p++) begin
         for (int a = 1; a < 64; a++) begin
            wv[a] = 8'((a * 37 + p * 91 + 5) & 255);
            wr(6'(a), wv[a]);
         end
         for (int a = 1; a < 64; a++)
            rd_chk("R2", 6'(a), mapped(a) ? wv[a] : 8'h00);
         chk("R2 index", cmd_index, wv[1]);
         chk("R2 code", cmd_rsp_code, wv[2]);
         chk("R2 arg", cmd_arg, {wv[7], wv[6], wv[5], wv[4]});
         chk("R2 count", blk_count, {wv[15], wv[14]});
         chk("R6 len", blk_len_m1, {wv[13][2:0], wv[12]});
         chk("R6 flags", blk_flags, wv[13][7:3]);
      end

      // R6 low-byte write keeps flags
      wr(6'h0D, 8'b1010_1101);
      wr(6'h0C, 8'h3C);
      chk("R6 flags kept", blk_flags, 5'b10101);
      chk("R6 len low", blk_len_m1, 11'h53C);

      // R3 command kinds and decode
      for (int k = 0; k < 16; k++) begin
         wr(6'h00, 8'((k << 4) | ((k & 1) << 2) | 2));
         chk("R3 kind", cmd_kind, k);
         chk("R3 write", cmd_write, k & 1);
         chk("R3 has_data", cmd_has_data, (k >= 1 && k <= 4));
         chk("R3 multi", cmd_multi, (k == 3 || k == 4));
         chk("R3 stop", cmd_stop, (k == 7));
         chk("R4 no start", cmd_start, 0);
         rd_chk("R3 readback", 6'h00, 8'((k << 4) | ((k & 1) << 2)));
      end

      // R7 response code decode
      for (int c = 0; c < 16; c++) begin
         wr(6'h02, 8'(c));
         chk("R7 busy", rsp_busy, (c == 9));
         chk("R7 long", rsp_long, (c == 2));
      end

      // R4 start pulse
      wr(6'h00, 8'h71);
      chk("R4 pulse", cmd_start, 1);
      chk("R4 bit0 set", reg_rdata, 8'h70 | 8'h01);
      chk("R3 stop kind", cmd_stop, 1);
      @(negedge clk); #1;
      chk("R4 pulse end", cmd_start, 0);
      chk("R4 bit0 clear", reg_rdata, 8'h70);

      // R5 start ignored while busy
      seq_busy = 1'b1;
      wr(6'h00, 8'h21);
      chk("R5 no pulse", cmd_start, 0);
      chk("R5 kind taken", cmd_kind, 2);
      @(negedge clk); #1;
      chk("R5 still none", cmd_start, 0);
      seq_busy = 1'b0;

      // R8 full load with rotation and overflow
      wr(6'h00, 8'h08);
      for (int k = 0; k < 16; k++) push(pat(k));
      push(8'hEE);
      push(8'hEE);
      for (int s = 0; s < 16; s++)
         rd_chk("R8 slot", 6'(16 + s), pat(s == 0 ? 15 : s - 1));
      // R2 writes into the response window are ignored
      wr(6'h13, 8'h99);
      rd_chk("R2 rsp write ignored", 6'h13, pat(2));
      // R8 start restarts the numbering
      wr(6'h00, 8'h01);
      push(8'h5A);
      rd_chk("R8 restart", 6'h11, 8'h5A);
      rd_chk("R8 others kept", 6'h12, pat(1));
      rd_chk("R8 last kept", 6'h10, pat(15));

      // R9 clear wins over a simultaneous push
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = 6'h00; reg_wdata = 8'h08;
      rsp_push = 1'b1; rsp_din = 8'h77;
      @(negedge clk);
      reg_wr = 1'b0; rsp_push = 1'b0;
      for (int s = 0; s < 16; s++) rd_chk("R9 cleared", 6'(16 + s), 8'h00);
      rd_chk("R9 bit3 reads 0", 6'h00, 8'h00);
      push(8'h33);
      rd_chk("R9 numbering restart", 6'h11, 8'h33);
      rd_chk("R9 base empty", 6'h10, 8'h00);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule